// File: doc/BRIEF.md
# Power State and Clock Gating Controller

This block decides which clocks and resets a small system-on-chip receives in each of its power states. It has three states: operating, idle and standby. It drives a processor clock enable and a processor reset, one enable and one reset per peripheral, the SDRAM controller enable with its self-refresh request, and the PLL enable. Software enters idle by writing to one fixed address on a simple bus write port; the data is irrelevant. The processor clock then stays gated until an interrupt arrives. A standby request input powers down most peripherals and places SDRAM in self-refresh. A wake pin or an interrupt brings the system back. On the way back the PLL is enabled first, and the processor clock follows after a lock delay.

A power-on reset input and a user reset input both hold the system in reset. The release is stretched by a parameterised count of cycles, so that the rest of the chip only leaves reset after supplies and inputs have settled. The real-time clock is treated apart from everything else: it is never reset and never gated. Every output is a register, so each state change shows on the outputs at the clock edge that samples its trigger.

Top module: `pwr_state_ctrl`

## Requirements
- R1: In operating, a write strobe on `bus_wr_en` with `bus_addr` equal to `HALT_ADDR` (default 0x8000_0800), with no interrupt pending and `stby_req` low, makes `pwr_state` read 01 (idle) after the next edge. A write to any other address leaves the state unchanged.
- R2: A halt write made while any bit of `irq_pend` is set has no effect, and `pwr_state` stays 00.
- R3: In idle, only `cpu_clk_en` is low. Every other output has its operating value. Any set bit of `irq_pend` returns the state to 00 at the next edge.
- R4: `stby_req` in operating enters standby (10), and it wins over a halt write in the same cycle. Standby outputs are as follows:
  - Enables off for the UART (bit 0), LCD (1), ADC (2), SSI (3), DAI (4), codec (5), timers (6), DC-to-DC (7) and LCD FIFO (8).
  - Only the LCD FIFO has its reset set (`per_rst` = 0x100).
  - The LED flasher (9), interrupt controller (10) and RTC (11) stay enabled, so `per_clk_en` = 0xE00.
  - `cpu_clk_en` and `pll_en` are low, and `sdram_en` and `sdram_selfref` are high.
- R5: In standby, `wake_pin` or any interrupt sets `pll_en` at the next edge. `pwr_state` stays 10 and self-refresh stays on until exactly `LOCK_CYC` edges after that one. At that edge the state becomes 00 and `cpu_clk_en` rises.
- R6: The RTC bit (11) of `per_clk_en` is always 1 and of `per_rst` is always 0, during resets included.
- R7: While reset is held, `cpu_rst` = 1, `cpu_clk_en` = 0, `pll_en` = 0, `sdram_selfref` = 0, `pwr_state` = 00, `per_clk_en` = 0x800 and `per_rst` = 0x7FF. `sdram_en` is 0 if `por_rst` started or joined the hold, and 1 after a user reset alone.
- R8: Outputs leave reset exactly `RST_HOLD` edges after the last edge that samples `por_rst` or `usr_rst` high. A reset during the stretch restarts the count.
- R9: In operating, all peripheral enables are 1 and all their resets are 0. `cpu_clk_en`, `pll_en` and `sdram_en` are 1, and `sdram_selfref` is 0.
- R10: `pwr_state` never reads 11, and `cpu_clk_en` is high only while `pwr_state` is 00.
- R11: In idle, `stby_req` and `wake_pin` are ignored; only an interrupt ends idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_rst | input | 1 | Power-on reset, active high, synchronous |
| usr_rst | input | 1 | User reset, active high, synchronous |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address |
| irq_pend | input | N_IRQ | Pending interrupt lines |
| stby_req | input | 1 | Request to enter standby |
| wake_pin | input | 1 | Dedicated wake from standby |
| pwr_state | output | 2 | 00 operating, 01 idle, 10 standby |
| cpu_clk_en | output | 1 | Processor clock enable |
| cpu_rst | output | 1 | Processor reset |
| pll_en | output | 1 | PLL enable |
| sdram_en | output | 1 | SDRAM controller enable |
| sdram_selfref | output | 1 | SDRAM self-refresh request |
| per_clk_en | output | 12 | Peripheral clock enables, bit order as in R4 |
| per_rst | output | 12 | Peripheral resets, same bit order |

## Verification
The bench goes after the following corner cases:
- A halt write that collides with a pending interrupt, which a faulty design would take into idle.
- A standby request in the same cycle as a halt write, where the wrong priority lands in idle.
- Standby or wake inputs while idle, which could wrongly leave idle.
- The wake sequence edge by edge, where an off-by-one lock counter or an early processor clock shows up as a state or enable one cycle out.
- A user reset re-asserted in the middle of the stretch. A counter that does not restart would release too early.
- The SDRAM enable under user reset versus power-on reset, and the RTC bits across every reset. A policy that treats all resets alike breaks both.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    localparam int NUM_PER    = 12;
    localparam int P_UART     = 0;
    localparam int P_LCD      = 1;
    localparam int P_ADC      = 2;
    localparam int P_SSI      = 3;
    localparam int P_DAI      = 4;
    localparam int P_CODEC    = 5;
    localparam int P_TIMER    = 6;
    localparam int P_DCDC     = 7;
    localparam int P_LCD_FIFO = 8;
    localparam int P_LED      = 9;
    localparam int P_INTC     = 10;
    localparam int P_RTC      = 11;

    localparam logic [NUM_PER-1:0] RTC_MASK  = NUM_PER'(1) << P_RTC;
    localparam logic [NUM_PER-1:0] FIFO_MASK = NUM_PER'(1) << P_LCD_FIFO;
    localparam logic [NUM_PER-1:0] KEEP_MASK = (NUM_PER'(1) << P_LED)
                                             | (NUM_PER'(1) << P_INTC)
                                             | RTC_MASK;

    // ST_WAKE is internal: PLL relocking, reported as standby
    typedef enum logic [1:0] {
        ST_OPER = 2'b00,
        ST_IDLE = 2'b01,
        ST_STBY = 2'b10,
        ST_WAKE = 2'b11
    } pwr_st_e;

    typedef struct packed {
        logic               cpu_clk_en;
        logic               cpu_rst;
        logic               pll_en;
        logic               sdram_en;
        logic               sdram_selfref;
        logic [NUM_PER-1:0] per_en;
        logic [NUM_PER-1:0] per_rst;
    } pwr_out_t;

    function automatic logic [1:0] status_code(pwr_st_e st);
        return (st == ST_WAKE) ? 2'(ST_STBY) : 2'(st);
    endfunction

    function automatic pwr_out_t policy(pwr_st_e st, logic hold, logic por);
        pwr_out_t o;
        o = '0;
        if (hold) begin
            o.cpu_rst  = 1'b1;
            o.sdram_en = ~por;
            o.per_en   = RTC_MASK;
            o.per_rst  = ~RTC_MASK;
        end else begin
            unique case (st)
                ST_OPER, ST_IDLE: begin
                    o.cpu_clk_en = (st == ST_OPER);
                    o.pll_en     = 1'b1;
                    o.sdram_en   = 1'b1;
                    o.per_en     = '1;
                end
                default: begin
                    o.pll_en        = (st == ST_WAKE);
                    o.sdram_en      = 1'b1;
                    o.sdram_selfref = 1'b1;
                    o.per_en        = KEEP_MASK;
                    o.per_rst       = FIFO_MASK;
                end
            endcase
        end
        return o;
    endfunction

endpackage

// File: rtl/pwr_rst_stretch.sv
module pwr_rst_stretch #(
    parameter int RST_HOLD = 12500
) (
    input  logic clk,
    input  logic por_rst,
    input  logic usr_rst,
    output logic hold_d,
    output logic por_d
);
    localparam int CNT_W = $clog2(RST_HOLD + 1);
    localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(RST_HOLD);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             por_q;

    always_comb begin
        if (por_rst || usr_rst)  cnt_d = '0;
        else if (cnt_q == HOLD_C) cnt_d = cnt_q;
        else                      cnt_d = cnt_q + 1'b1;
        hold_d = (cnt_d != HOLD_C);
        por_d  = por_rst | (hold_d & por_q);
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
        por_q <= por_d;
    end
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_pkg::*;
#(
    parameter int LOCK_CYC = 64
) (
    input  logic    clk,
    input  logic    hold_d,
    input  logic    halt_wr,
    input  logic    irq_any,
    input  logic    stby_req,
    input  logic    wake_pin,
    output pwr_st_e state_d,
    output pwr_st_e state_q
);
    localparam int LK_W = (LOCK_CYC > 1) ? $clog2(LOCK_CYC) : 1;
    localparam logic [LK_W-1:0] LK_LAST = LK_W'(LOCK_CYC - 1);

    logic [LK_W-1:0] lock_q, lock_d;

    always_comb begin
        state_d = state_q;
        lock_d  = lock_q;
        if (hold_d) begin
            state_d = ST_OPER;
            lock_d  = '0;
        end else begin
            unique case (state_q)
                ST_OPER: begin
                    if (stby_req)                 state_d = ST_STBY;
                    else if (halt_wr && !irq_any) state_d = ST_IDLE;
                end
                ST_IDLE: if (irq_any) state_d = ST_OPER;
                ST_STBY: begin
                    if (wake_pin || irq_any) begin
                        state_d = ST_WAKE;
                        lock_d  = '0;
                    end
                end
                default: begin
                    if (lock_q == LK_LAST) state_d = ST_OPER;
                    else                   lock_d  = lock_q + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
        lock_q  <= lock_d;
    end
endmodule

// File: rtl/pwr_outmap.sv
module pwr_outmap
    import pwr_pkg::*;
(
    input  logic               clk,
    input  pwr_st_e            state_d,
    input  logic               hold_d,
    input  logic               por_d,
    output logic               cpu_clk_en,
    output logic               cpu_rst,
    output logic               pll_en,
    output logic               sdram_en,
    output logic               sdram_selfref,
    output logic [NUM_PER-1:0] per_clk_en,
    output logic [NUM_PER-1:0] per_rst
);
    pwr_out_t nxt;
    assign nxt = policy(state_d, hold_d, por_d);

    always_ff @(posedge clk) begin
        cpu_clk_en    <= nxt.cpu_clk_en;
        cpu_rst       <= nxt.cpu_rst;
        pll_en        <= nxt.pll_en;
        sdram_en      <= nxt.sdram_en;
        sdram_selfref <= nxt.sdram_selfref;
    end

    for (genvar i = 0; i < NUM_PER; i++) begin : g_per
        always_ff @(posedge clk) begin
            per_clk_en[i] <= nxt.per_en[i];
            per_rst[i]    <= nxt.per_rst[i];
        end
    end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import pwr_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] HALT_ADDR = ADDR_W'(32'h8000_0800),
    parameter int                N_IRQ     = 8,
    parameter int                RST_HOLD  = 12500,
    parameter int                LOCK_CYC  = 64
) (
    input  logic               clk,
    input  logic               por_rst,
    input  logic               usr_rst,
    input  logic               bus_wr_en,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [N_IRQ-1:0]   irq_pend,
    input  logic               stby_req,
    input  logic               wake_pin,
    output logic [1:0]         pwr_state,
    output logic               cpu_clk_en,
    output logic               cpu_rst,
    output logic               pll_en,
    output logic               sdram_en,
    output logic               sdram_selfref,
    output logic [NUM_PER-1:0] per_clk_en,
    output logic [NUM_PER-1:0] per_rst
);
    logic    hold_d, por_d, halt_wr, irq_any;
    pwr_st_e state_d, state_q;

    assign halt_wr = bus_wr_en && (bus_addr == HALT_ADDR);
    assign irq_any = |irq_pend;

    pwr_rst_stretch #(.RST_HOLD(RST_HOLD)) u_stretch (
        .clk(clk), .por_rst(por_rst), .usr_rst(usr_rst),
        .hold_d(hold_d), .por_d(por_d)
    );

    pwr_fsm #(.LOCK_CYC(LOCK_CYC)) u_fsm (
        .clk(clk), .hold_d(hold_d), .halt_wr(halt_wr), .irq_any(irq_any),
        .stby_req(stby_req), .wake_pin(wake_pin),
        .state_d(state_d), .state_q(state_q)
    );

    pwr_outmap u_out (
        .clk(clk), .state_d(state_d), .hold_d(hold_d), .por_d(por_d),
        .cpu_clk_en(cpu_clk_en), .cpu_rst(cpu_rst), .pll_en(pll_en),
        .sdram_en(sdram_en), .sdram_selfref(sdram_selfref),
        .per_clk_en(per_clk_en), .per_rst(per_rst)
    );

    assign pwr_state = status_code(state_q);
endmodule

// File: rtl/pwr_state_chk.sv
module pwr_state_chk
    import pwr_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] HALT_ADDR = '0,
    parameter int                N_IRQ     = 8
) (
    input logic               clk,
    input logic               por_rst,
    input logic               usr_rst,
    input logic               bus_wr_en,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [N_IRQ-1:0]   irq_pend,
    input logic               stby_req,
    input logic               wake_pin,
    input logic [1:0]         pwr_state,
    input logic               cpu_clk_en,
    input logic               cpu_rst,
    input logic               pll_en,
    input logic               sdram_en,
    input logic               sdram_selfref,
    input logic [NUM_PER-1:0] per_clk_en,
    input logic [NUM_PER-1:0] per_rst
);
    logic armed  = 1'b0;
    logic armed2 = 1'b0;
    always_ff @(posedge clk) begin
        armed  <= armed | por_rst | usr_rst;
        armed2 <= armed;
    end

    logic halt_hit;
    assign halt_hit = bus_wr_en && (bus_addr == HALT_ADDR) && !stby_req
                      && !por_rst && !usr_rst;

    // R1
    halt_enter_chk: assert property (@(posedge clk) disable iff (!armed)
        (pwr_state == 2'b00 && !cpu_rst && halt_hit && irq_pend == '0)
        |=> pwr_state == 2'b01);

    // R2
    halt_blocked_chk: assert property (@(posedge clk) disable iff (!armed)
        (pwr_state == 2'b00 && halt_hit && irq_pend != '0)
        |=> pwr_state == 2'b00);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!armed)
        (pwr_state == 2'b01 && irq_pend == '0 && !por_rst && !usr_rst
         && (stby_req || wake_pin || !stby_req))
        |=> pwr_state == 2'b01);

    // R4
    stby_out_chk: assert property (@(posedge clk) disable iff (!armed)
        (pwr_state == 2'b10) |-> (sdram_selfref && sdram_en && !cpu_clk_en
         && !per_clk_en[P_UART] && per_rst[P_LCD_FIFO] && per_clk_en[P_INTC]));

    // R5
    pll_first_chk: assert property (@(posedge clk) disable iff (!armed2)
        ($rose(cpu_clk_en) && $past(pwr_state) == 2'b10) |-> $past(pll_en));

    // R6
    rtc_alive_chk: assert property (@(posedge clk) disable iff (!armed)
        per_clk_en[P_RTC] && !per_rst[P_RTC]);

    // R7
    rst_hold_chk: assert property (@(posedge clk) disable iff (!armed)
        (por_rst || usr_rst) |=> (cpu_rst && !cpu_clk_en && !pll_en
         && pwr_state == 2'b00));

    // R7
    por_sdram_chk: assert property (@(posedge clk) disable iff (!armed)
        por_rst |=> !sdram_en);

    // R10
    cpu_only_oper_chk: assert property (@(posedge clk) disable iff (!armed)
        cpu_clk_en |-> pwr_state == 2'b00);

    // R10
    state_code_chk: assert property (@(posedge clk) disable iff (!armed)
        pwr_state != 2'b11);
endmodule

bind pwr_state_ctrl pwr_state_chk #(
    .ADDR_W(ADDR_W), .HALT_ADDR(HALT_ADDR), .N_IRQ(N_IRQ)
) u_chk (.*);

// File: tb/pwr_state_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_state_ctrl_bench;
    localparam int          HOLD = 10;
    localparam int          LOCK = 4;
    localparam int          NIRQ = 4;
    localparam logic [31:0] HALT = 32'h8000_0800;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1, usr_rst = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [NIRQ-1:0] irq_pend = '0;
    logic        stby_req = 1'b0, wake_pin = 1'b0;
    logic [1:0]  pwr_state;
    logic        cpu_clk_en, cpu_rst, pll_en, sdram_en, sdram_selfref;
    logic [11:0] per_clk_en, per_rst;

    int errors = 0, checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwr_state_ctrl #(.ADDR_W(32), .HALT_ADDR(HALT), .N_IRQ(NIRQ),
                     .RST_HOLD(HOLD), .LOCK_CYC(LOCK)) u_pwr_state_ctrl (
        .clk(clk), .por_rst(por_rst), .usr_rst(usr_rst),
        .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .irq_pend(irq_pend),
        .stby_req(stby_req), .wake_pin(wake_pin), .pwr_state(pwr_state),
        .cpu_clk_en(cpu_clk_en), .cpu_rst(cpu_rst), .pll_en(pll_en),
        .sdram_en(sdram_en), .sdram_selfref(sdram_selfref),
        .per_clk_en(per_clk_en), .per_rst(per_rst)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: mode 0 oper, 1 idle, 2 standby, 3 relocking
    int m_mode = 0, m_cnt = 0, m_lock = 0;
    bit m_por = 0, m_hold = 1, m_valid = 0;

    always @(posedge clk) begin
        logic [31:0] exp_v, act_v;
        string tag;
        if (por_rst || usr_rst) m_cnt = 0;
        else if (m_cnt < HOLD)  m_cnt = m_cnt + 1;
        m_hold = (m_cnt < HOLD);
        if (por_rst)      m_por = 1;
        else if (!m_hold) m_por = 0;
        if (m_hold) begin
            m_mode = 0;
        end else if (m_mode == 0) begin
            if (stby_req) m_mode = 2;
            else if (bus_wr_en && bus_addr == HALT && irq_pend == 0) m_mode = 1;
        end else if (m_mode == 1) begin
            if (irq_pend != 0) m_mode = 0;
        end else if (m_mode == 2) begin
            if (wake_pin || irq_pend != 0) begin m_mode = 3; m_lock = 0; end
        end else begin
            m_lock = m_lock + 1;
            if (m_lock == LOCK) m_mode = 0;
        end
        m_valid = 1;
        #2;
        if (m_hold) begin
            tag = "R7";
            exp_v = {2'b00, 1'b0, 1'b1, 1'b0, !m_por, 1'b0, 12'h800, 12'h7FF};
        end else if (m_mode == 0) begin
            tag = "R9";
            exp_v = {2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 12'hFFF, 12'h000};
        end else if (m_mode == 1) begin
            tag = "R3";
            exp_v = {2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 12'hFFF, 12'h000};
        end else begin
            tag = (m_mode == 3) ? "R5" : "R4";
            exp_v = {2'b10, 1'b0, 1'b0, 1'(m_mode == 3), 1'b1, 1'b1, 12'hE00, 12'h100};
        end
        act_v = {pwr_state, cpu_clk_en, cpu_rst, pll_en, sdram_en, sdram_selfref,
                 per_clk_en, per_rst};
        check(tag, act_v, exp_v);
        // R6 RTC bit alive in every cycle; R10 state code 11 never shown
        check("R6", {30'd0, per_clk_en[11], per_rst[11]}, 32'd2);
        check("R10", 32'(pwr_state == 2'b11), 32'd0);
    end

    task automatic halt_write(input logic [31:0] a);
        @(negedge clk); bus_wr_en = 1'b1; bus_addr = a;
        @(negedge clk); bus_wr_en = 1'b0; bus_addr = '0;
    endtask

    task automatic pulse_stby();
        @(negedge clk); stby_req = 1'b1;
        @(negedge clk); stby_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R7", 32'(cpu_rst), 32'd1);
        check("R7", 32'(sdram_en), 32'd0);
        check("R6", 32'(per_clk_en[11]), 32'd1);
        por_rst = 1'b0;
        repeat (HOLD - 1) @(posedge clk);
        @(negedge clk); check("R8", 32'(cpu_rst), 32'd1);
        @(negedge clk); check("R8", 32'(cpu_rst), 32'd0);
        check("R9", 32'(per_clk_en), 32'hFFF);

        halt_write(32'h8000_0804);
        check("R1", 32'(pwr_state), 32'd0);
        halt_write(HALT);
        check("R1", 32'(pwr_state), 32'd1);
        check("R3", 32'(cpu_clk_en), 32'd0);
        check("R3", 32'(per_clk_en), 32'hFFF);

        @(negedge clk); stby_req = 1'b1; wake_pin = 1'b1;
        @(negedge clk); stby_req = 1'b0; wake_pin = 1'b0;
        check("R11", 32'(pwr_state), 32'd1);
        @(negedge clk); irq_pend = 4'b0010;
        @(negedge clk); irq_pend = '0;
        check("R3", 32'(pwr_state), 32'd0);
        check("R3", 32'(cpu_clk_en), 32'd1);

        @(negedge clk); irq_pend = 4'b0001; bus_wr_en = 1'b1; bus_addr = HALT;
        @(negedge clk); irq_pend = '0; bus_wr_en = 1'b0;
        check("R2", 32'(pwr_state), 32'd0);
        check("R2", 32'(cpu_clk_en), 32'd1);

        @(negedge clk); stby_req = 1'b1; bus_wr_en = 1'b1; bus_addr = HALT;
        @(negedge clk); stby_req = 1'b0; bus_wr_en = 1'b0;
        check("R4", 32'(pwr_state), 32'd2);
        check("R4", 32'(per_clk_en), 32'hE00);
        check("R4", 32'(per_rst), 32'h100);
        check("R4", {30'd0, sdram_selfref, pll_en}, 32'd2);
        repeat (3) @(negedge clk);
        check("R4", 32'(pwr_state), 32'd2);

        @(negedge clk); wake_pin = 1'b1;
        @(negedge clk); wake_pin = 1'b0;
        check("R5", {29'd0, pll_en, cpu_clk_en, sdram_selfref}, 32'd5);
        repeat (LOCK - 1) @(posedge clk);
        @(negedge clk);
        check("R5", {29'd0, pwr_state, cpu_clk_en}, 32'd4);
        @(negedge clk);
        check("R5", {29'd0, pwr_state, cpu_clk_en}, 32'd1);
        check("R5", 32'(sdram_selfref), 32'd0);

        pulse_stby();
        repeat (2) @(negedge clk);
        @(negedge clk); irq_pend = 4'b1000;
        @(negedge clk); irq_pend = '0;
        check("R5", 32'(pll_en), 32'd1);
        repeat (LOCK) @(negedge clk);
        check("R5", 32'(pwr_state), 32'd0);

        halt_write(HALT);
        @(negedge clk); usr_rst = 1'b1;
        @(negedge clk); usr_rst = 1'b0;
        check("R7", {29'd0, cpu_rst, sdram_en, 1'(pwr_state == 0)}, 32'd7);
        repeat (HOLD - 3) @(posedge clk);
        @(negedge clk); usr_rst = 1'b1;
        @(negedge clk); usr_rst = 1'b0;
        repeat (HOLD - 1) @(posedge clk);
        @(negedge clk); check("R8", 32'(cpu_rst), 32'd1);
        @(negedge clk); check("R8", 32'(cpu_rst), 32'd0);

        pulse_stby();
        @(negedge clk); por_rst = 1'b1;
        @(negedge clk); por_rst = 1'b0;
        check("R7", {30'd0, sdram_en, sdram_selfref}, 32'd0);
        repeat (HOLD + 1) @(negedge clk);
        check("R9", {29'd0, pwr_state, cpu_clk_en}, 32'd1);

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule